// File: doc/BRIEF.md
# Outstanding Transaction Limiter

This block sits between a master and the interconnect, on the write-address and read-address channels. It keeps a count of how many write and read requests have been accepted downstream and are still waiting for their completion, and it withholds a channel's valid and ready whenever letting another request through would exceed a limit. There is a fixed design-time ceiling per channel. There are also optional programmed limits: one per channel, and one on the sum of reads and writes, which is applied after the per-channel limits.

Each programmed limit is a fixed-point number made of an integer part and an 8-bit binary fraction. A non-zero fraction bounds the average number of outstanding requests rather than the instantaneous number. An occupancy accumulator adds the current count every cycle and subtracts the limit. A request that would take the count one above the integer part is admitted only when this accumulator has drained to zero. With a limit of 0.5, a master that waits 50 cycles for each response is therefore held to about one request every 100 cycles.

With every enable low, only the ceilings gate the channels. The gating is purely combinational, so an idle limiter adds no cycle of latency.

Top module: `outstandingLimiter`

## Requirements
- R1: An accepted write address (awValidOut and awReadyIn high together) raises the write count by one, and a wrRespDone pulse lowers it by one if it is non-zero. When both happen in the same cycle, the count is unchanged. Reads behave the same way with arValidOut, arReadyIn and rdRespDone.
- R2: A channel whose count equals its design ceiling (WR_CEIL or RD_CEIL, at most 32) has its valid and ready outputs held low, whatever the enables are.
- R3: With the channel's enable bit set (enable[0] for writes, enable[1] for reads), a zero fraction and a non-zero integer part below the ceiling, the channel is held off while its count is at or above the integer part.
- R4: A limit whose integer and fractional parts are both zero, or whose integer part is at or above the ceiling, has no effect, and only the ceiling applies.
- R5: With a non-zero fraction F and integer part I, a channel at count I is admitted only when its accumulator is zero. Below I it is admitted freely. At each clock the accumulator becomes max(0, acc + count*256 - (I*256+F)), using the count before that clock.
- R6: With enable[2] set, the combined limit (7-bit integer, 8-bit fraction) is applied to writes plus reads by the rules of R3 and R5, with its own accumulator. It has no effect when zero or when its integer part is at or above WR_CEIL+RD_CEIL.
- R7: When both channels pass their own limits and both request, but the combined limit leaves room for exactly one, only one is admitted. Writes go first after reset, and the turn passes to the other channel each time the admitted request is accepted.
- R8: A valid or ready output is high only if its input is high and the channel is admitted in that cycle. An input ready that is low means no request is accepted.
- R9: With enable all zero and both counts below their ceilings, each valid and ready output equals its input in the same cycle.
- R10: After reset, both counts and all accumulators are zero. An accumulator is held at zero while its enable is low or its fraction is zero, so it restarts on every re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 3 | bit0 write limit, bit1 read limit, bit2 combined limit |
| wrLimInt | input | 6 | Write limit integer part |
| wrLimFrac | input | 8 | Write limit fraction |
| rdLimInt | input | 6 | Read limit integer part |
| rdLimFrac | input | 8 | Read limit fraction |
| cbLimInt | input | 7 | Combined limit integer part |
| cbLimFrac | input | 8 | Combined limit fraction |
| awValidIn | input | 1 | Write address valid from master |
| awReadyOut | output | 1 | Gated write address ready to master |
| awValidOut | output | 1 | Gated write address valid downstream |
| awReadyIn | input | 1 | Write address ready from downstream |
| arValidIn | input | 1 | Read address valid from master |
| arReadyOut | output | 1 | Gated read address ready to master |
| arValidOut | output | 1 | Gated read address valid downstream |
| arReadyIn | input | 1 | Read address ready from downstream |
| wrRespDone | input | 1 | One pulse per completed write |
| rdRespDone | input | 1 | One pulse per completed read |

## Verification
The bound checker keeps its own outstanding counts from the port handshakes. On every cycle it checks that the ceilings, whole-number limits and combined cap are never exceeded, that two grants never share a single combined slot, that the outputs never assert without their inputs, and that the block is transparent when disabled. Fractional pacing, accumulator restart on re-enable, alternation order, and the exact cycle in which a held channel reopens depend on accumulated history. Only the bench's cycle-by-cycle scoreboard against an independent model of the requirements shows these.

// File: rtl/ostlPkg.sv
package ostlPkg;
  localparam int FRAC_W = 8;

  typedef struct packed {
    logic wrIssue;
    logic wrDone;
    logic rdIssue;
    logic rdDone;
    logic wrAccClr;
    logic rdAccClr;
    logic cbAccClr;
  } ostlStrobes_t;
endpackage

// File: rtl/ostlAccum.sv
module ostlAccum #(
  parameter int CNT_W = 3,
  parameter int INT_W = 6,
  parameter int ACC_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      clr,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [INT_W-1:0]          limInt,
  input  logic [ostlPkg::FRAC_W-1:0] limFrac,
  output logic                      accPos
);
  localparam int FW    = ostlPkg::FRAC_W;
  localparam int PADC  = ACC_W + 1 - CNT_W - FW;
  localparam int PADL  = ACC_W + 1 - INT_W - FW;

  logic [ACC_W-1:0] acc, accNext;
  logic [ACC_W:0]   grown, limExt, diff;

  always_comb begin
    grown  = {1'b0, acc} + {{PADC{1'b0}}, cnt, {FW{1'b0}}};
    limExt = {{PADL{1'b0}}, limInt, limFrac};
    diff   = grown - limExt;
    if (grown > limExt) begin
      accNext = diff[ACC_W] ? {ACC_W{1'b1}} : diff[ACC_W-1:0];
    end else begin
      accNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) acc <= '0;
    else              acc <= accNext;
  end

  assign accPos = |acc;
endmodule

// File: rtl/ostlDatapath.sv
module ostlDatapath #(
  parameter int WR_CEIL = 4,
  parameter int RD_CEIL = 4,
  parameter int ACC_W   = 16,
  localparam int WR_CNT_W = $clog2(WR_CEIL + 1),
  localparam int RD_CNT_W = $clog2(RD_CEIL + 1),
  localparam int CB_CNT_W = $clog2(WR_CEIL + RD_CEIL + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ostlPkg::ostlStrobes_t strb,
  input  logic [5:0]           wrLimInt,
  input  logic [7:0]           wrLimFrac,
  input  logic [5:0]           rdLimInt,
  input  logic [7:0]           rdLimFrac,
  input  logic [6:0]           cbLimInt,
  input  logic [7:0]           cbLimFrac,
  output logic [WR_CNT_W-1:0]  wrCnt,
  output logic [RD_CNT_W-1:0]  rdCnt,
  output logic [CB_CNT_W-1:0]  cbCnt,
  output logic                 wrAccPos,
  output logic                 rdAccPos,
  output logic                 cbAccPos
);
  logic wrDec, rdDec;
  assign wrDec = strb.wrDone && (wrCnt != '0);
  assign rdDec = strb.rdDone && (rdCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      if (strb.wrIssue && !wrDec)      wrCnt <= wrCnt + 1'b1;
      else if (!strb.wrIssue && wrDec) wrCnt <= wrCnt - 1'b1;
      if (strb.rdIssue && !rdDec)      rdCnt <= rdCnt + 1'b1;
      else if (!strb.rdIssue && rdDec) rdCnt <= rdCnt - 1'b1;
    end
  end

  assign cbCnt = CB_CNT_W'(wrCnt) + CB_CNT_W'(rdCnt);

  ostlAccum #(.CNT_W(WR_CNT_W), .INT_W(6), .ACC_W(ACC_W)) u_wrAcc (
    .clk(clk), .rstN(rstN), .clr(strb.wrAccClr), .cnt(wrCnt),
    .limInt(wrLimInt), .limFrac(wrLimFrac), .accPos(wrAccPos));

  ostlAccum #(.CNT_W(RD_CNT_W), .INT_W(6), .ACC_W(ACC_W)) u_rdAcc (
    .clk(clk), .rstN(rstN), .clr(strb.rdAccClr), .cnt(rdCnt),
    .limInt(rdLimInt), .limFrac(rdLimFrac), .accPos(rdAccPos));

  ostlAccum #(.CNT_W(CB_CNT_W), .INT_W(7), .ACC_W(ACC_W)) u_cbAcc (
    .clk(clk), .rstN(rstN), .clr(strb.cbAccClr), .cnt(cbCnt),
    .limInt(cbLimInt), .limFrac(cbLimFrac), .accPos(cbAccPos));
endmodule

// File: rtl/ostlControl.sv
module ostlControl #(
  parameter int WR_CEIL = 4,
  parameter int RD_CEIL = 4,
  localparam int WR_CNT_W = $clog2(WR_CEIL + 1),
  localparam int RD_CNT_W = $clog2(RD_CEIL + 1),
  localparam int CB_CNT_W = $clog2(WR_CEIL + RD_CEIL + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            enable,
  input  logic [5:0]            wrLimInt,
  input  logic [7:0]            wrLimFrac,
  input  logic [5:0]            rdLimInt,
  input  logic [7:0]            rdLimFrac,
  input  logic [6:0]            cbLimInt,
  input  logic [7:0]            cbLimFrac,
  input  logic [WR_CNT_W-1:0]   wrCnt,
  input  logic [RD_CNT_W-1:0]   rdCnt,
  input  logic [CB_CNT_W-1:0]   cbCnt,
  input  logic                  wrAccPos,
  input  logic                  rdAccPos,
  input  logic                  cbAccPos,
  input  logic                  awValidIn,
  input  logic                  awReadyIn,
  input  logic                  arValidIn,
  input  logic                  arReadyIn,
  input  logic                  wrRespDone,
  input  logic                  rdRespDone,
  output logic                  awValidOut,
  output logic                  awReadyOut,
  output logic                  arValidOut,
  output logic                  arReadyOut,
  output ostlPkg::ostlStrobes_t strb
);
  function automatic logic admit(input logic [7:0] cnt, input logic [7:0] limI,
                                 input logic fracNz, input logic accPos);
    return (cnt < limI) || ((cnt == limI) && fracNz && !accPos);
  endfunction

  logic wrOn, rdOn, cbOn, wrOk, rdOk, cbOk, cbTwo, conflict, wrGate, rdGate;
  logic prefRd;

  always_comb begin
    wrOn  = enable[0] && ((wrLimInt != '0) || (wrLimFrac != '0)) && (8'(wrLimInt) < 8'(WR_CEIL));
    rdOn  = enable[1] && ((rdLimInt != '0) || (rdLimFrac != '0)) && (8'(rdLimInt) < 8'(RD_CEIL));
    cbOn  = enable[2] && ((cbLimInt != '0) || (cbLimFrac != '0)) &&
            (8'(cbLimInt) < 8'(WR_CEIL + RD_CEIL));
    wrOk  = (8'(wrCnt) < 8'(WR_CEIL)) &&
            (!wrOn || admit(8'(wrCnt), 8'(wrLimInt), |wrLimFrac, wrAccPos));
    rdOk  = (8'(rdCnt) < 8'(RD_CEIL)) &&
            (!rdOn || admit(8'(rdCnt), 8'(rdLimInt), |rdLimFrac, rdAccPos));
    cbOk  = !cbOn || admit(8'(cbCnt), 8'(cbLimInt), |cbLimFrac, cbAccPos);
    cbTwo = !cbOn || admit(8'(cbCnt) + 8'd1, 8'(cbLimInt), |cbLimFrac, cbAccPos);
    conflict = awValidIn && arValidIn && wrOk && rdOk && cbOk && !cbTwo;
    wrGate = wrOk && cbOk && !(conflict && prefRd);
    rdGate = rdOk && cbOk && !(conflict && !prefRd);
  end

  assign awValidOut = awValidIn && wrGate;
  assign awReadyOut = awReadyIn && wrGate;
  assign arValidOut = arValidIn && rdGate;
  assign arReadyOut = arReadyIn && rdGate;

  always_comb begin
    strb.wrIssue  = awValidOut && awReadyIn;
    strb.rdIssue  = arValidOut && arReadyIn;
    strb.wrDone   = wrRespDone;
    strb.rdDone   = rdRespDone;
    strb.wrAccClr = !enable[0] || (wrLimFrac == '0);
    strb.rdAccClr = !enable[1] || (rdLimFrac == '0);
    strb.cbAccClr = !enable[2] || (cbLimFrac == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) prefRd <= 1'b0;
    else if (conflict && (prefRd ? strb.rdIssue : strb.wrIssue)) prefRd <= !prefRd;
  end
endmodule

// File: rtl/outstandingLimiter.sv
module outstandingLimiter #(
  parameter int WR_CEIL = 4,
  parameter int RD_CEIL = 4,
  parameter int ACC_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] enable,
  input  logic [5:0] wrLimInt,
  input  logic [7:0] wrLimFrac,
  input  logic [5:0] rdLimInt,
  input  logic [7:0] rdLimFrac,
  input  logic [6:0] cbLimInt,
  input  logic [7:0] cbLimFrac,
  input  logic       awValidIn,
  output logic       awReadyOut,
  output logic       awValidOut,
  input  logic       awReadyIn,
  input  logic       arValidIn,
  output logic       arReadyOut,
  output logic       arValidOut,
  input  logic       arReadyIn,
  input  logic       wrRespDone,
  input  logic       rdRespDone
);
  localparam int WR_CNT_W = $clog2(WR_CEIL + 1);
  localparam int RD_CNT_W = $clog2(RD_CEIL + 1);
  localparam int CB_CNT_W = $clog2(WR_CEIL + RD_CEIL + 1);

  ostlPkg::ostlStrobes_t strb;
  logic [WR_CNT_W-1:0] wrCnt;
  logic [RD_CNT_W-1:0] rdCnt;
  logic [CB_CNT_W-1:0] cbCnt;
  logic wrAccPos, rdAccPos, cbAccPos;

  ostlDatapath #(.WR_CEIL(WR_CEIL), .RD_CEIL(RD_CEIL), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrLimInt(wrLimInt), .wrLimFrac(wrLimFrac),
    .rdLimInt(rdLimInt), .rdLimFrac(rdLimFrac),
    .cbLimInt(cbLimInt), .cbLimFrac(cbLimFrac),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .cbCnt(cbCnt),
    .wrAccPos(wrAccPos), .rdAccPos(rdAccPos), .cbAccPos(cbAccPos));

  ostlControl #(.WR_CEIL(WR_CEIL), .RD_CEIL(RD_CEIL)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .wrLimInt(wrLimInt), .wrLimFrac(wrLimFrac),
    .rdLimInt(rdLimInt), .rdLimFrac(rdLimFrac),
    .cbLimInt(cbLimInt), .cbLimFrac(cbLimFrac),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .cbCnt(cbCnt),
    .wrAccPos(wrAccPos), .rdAccPos(rdAccPos), .cbAccPos(cbAccPos),
    .awValidIn(awValidIn), .awReadyIn(awReadyIn),
    .arValidIn(arValidIn), .arReadyIn(arReadyIn),
    .wrRespDone(wrRespDone), .rdRespDone(rdRespDone),
    .awValidOut(awValidOut), .awReadyOut(awReadyOut),
    .arValidOut(arValidOut), .arReadyOut(arReadyOut),
    .strb(strb));
endmodule

// File: rtl/ostlChecker.sv
module ostlChecker #(
  parameter int WR_CEIL = 4,
  parameter int RD_CEIL = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] enable,
  input logic [5:0] wrLimInt,
  input logic [7:0] wrLimFrac,
  input logic [5:0] rdLimInt,
  input logic [7:0] rdLimFrac,
  input logic [6:0] cbLimInt,
  input logic [7:0] cbLimFrac,
  input logic       awValidIn,
  input logic       awReadyOut,
  input logic       awValidOut,
  input logic       awReadyIn,
  input logic       arValidIn,
  input logic       arReadyOut,
  input logic       arValidOut,
  input logic       arReadyIn,
  input logic       wrRespDone,
  input logic       rdRespDone
);
  logic [7:0] chkWr, chkRd, chkSum;
  logic cbIntOnly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkWr <= '0;
      chkRd <= '0;
    end else begin
      chkWr <= chkWr + 8'(awValidOut && awReadyIn) - 8'(wrRespDone && (chkWr != 0));
      chkRd <= chkRd + 8'(arValidOut && arReadyIn) - 8'(rdRespDone && (chkRd != 0));
    end
  end

  assign chkSum    = chkWr + chkRd;
  assign cbIntOnly = enable[2] && (cbLimFrac == 0) && (cbLimInt != 0) &&
                     (8'(cbLimInt) < 8'(WR_CEIL + RD_CEIL));

  AST_WR_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (chkWr >= 8'(WR_CEIL)) |-> !awValidOut && !awReadyOut); // R2
  AST_RD_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (chkRd >= 8'(RD_CEIL)) |-> !arValidOut && !arReadyOut); // R2
  AST_WR_INT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (enable[0] && wrLimFrac == 0 && wrLimInt != 0 && 8'(wrLimInt) < 8'(WR_CEIL) &&
     chkWr >= 8'(wrLimInt)) |-> !awValidOut); // R3
  AST_RD_INT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (enable[1] && rdLimFrac == 0 && rdLimInt != 0 && 8'(rdLimInt) < 8'(RD_CEIL) &&
     chkRd >= 8'(rdLimInt)) |-> !arValidOut); // R3
  AST_COMB_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (cbIntOnly && chkSum >= 8'(cbLimInt)) |-> !awValidOut && !arValidOut); // R6
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (cbIntOnly && chkSum + 8'd1 == 8'(cbLimInt)) |-> !(awValidOut && arValidOut)); // R7
  AST_AW_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (awValidOut |-> awValidIn) and (awReadyOut |-> awReadyIn)); // R8
  AST_AR_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (arValidOut |-> arValidIn) and (arReadyOut |-> arReadyIn)); // R8
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (enable == 3'b000 && chkWr < 8'(WR_CEIL) && chkRd < 8'(RD_CEIL)) |->
    (awValidOut == awValidIn && arValidOut == arValidIn)); // R9
endmodule

bind outstandingLimiter ostlChecker #(.WR_CEIL(WR_CEIL), .RD_CEIL(RD_CEIL)) u_ostlChecker (
  .clk(clk), .rstN(rstN), .enable(enable),
  .wrLimInt(wrLimInt), .wrLimFrac(wrLimFrac),
  .rdLimInt(rdLimInt), .rdLimFrac(rdLimFrac),
  .cbLimInt(cbLimInt), .cbLimFrac(cbLimFrac),
  .awValidIn(awValidIn), .awReadyOut(awReadyOut), .awValidOut(awValidOut), .awReadyIn(awReadyIn),
  .arValidIn(arValidIn), .arReadyOut(arReadyOut), .arValidOut(arValidOut), .arReadyIn(arReadyIn),
  .wrRespDone(wrRespDone), .rdRespDone(rdRespDone));

// File: tb/outstandingLimiter_bench.sv
`timescale 1ns/1ps
module outstandingLimiter_bench;
  localparam int WCEIL = 4;
  localparam int RCEIL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] enable = '0;
  logic [5:0] wrLimInt = '0, rdLimInt = '0;
  logic [7:0] wrLimFrac = '0, rdLimFrac = '0, cbLimFrac = '0;
  logic [6:0] cbLimInt = '0;
  logic awValidIn = 0, awReadyIn = 0, arValidIn = 0, arReadyIn = 0;
  logic wrRespDone = 0, rdRespDone = 0;
  logic awValidOut, awReadyOut, arValidOut, arReadyOut;

  always #4 clk = ~clk;

  outstandingLimiter #(.WR_CEIL(WCEIL), .RD_CEIL(RCEIL)) u_outstandingLimiter (
    .clk(clk), .rstN(rstN), .enable(enable),
    .wrLimInt(wrLimInt), .wrLimFrac(wrLimFrac),
    .rdLimInt(rdLimInt), .rdLimFrac(rdLimFrac),
    .cbLimInt(cbLimInt), .cbLimFrac(cbLimFrac),
    .awValidIn(awValidIn), .awReadyOut(awReadyOut), .awValidOut(awValidOut), .awReadyIn(awReadyIn),
    .arValidIn(arValidIn), .arReadyOut(arReadyOut), .arValidOut(arValidOut), .arReadyIn(arReadyIn),
    .wrRespDone(wrRespDone), .rdRespDone(rdRespDone));

  // stimulus intent and reference model state
  bit awV, awR, arV, arR, wForce, rForce;
  int wLat, rLat, wTmr, rTmr;
  int mWr, mRd, accW, accR, accC;
  bit mPref;
  int checks = 0, fails = 0;
  bit finished = 0;

  bit [3:0] expQ[$];
  string    tagQ[$];
  bit [3:0] expV, gotV;
  string    tagV;

  function automatic bit admitF(int cnt, int li, int fr, int acc);
    return (cnt < li) || (cnt == li && fr != 0 && acc == 0);
  endfunction

  function automatic int stepAcc(bit on, int acc, int cnt, int li, int fr);
    int v;
    if (!on) return 0;
    v = acc + cnt * 256 - (li * 256 + fr);
    return (v > 0) ? v : 0;
  endfunction

  // scoreboard monitor: samples away from the active edge
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expV = expQ.pop_front();
      tagV = tagQ.pop_front();
      gotV = {awValidOut, awReadyOut, arValidOut, arReadyOut};
      checks++;
      if (gotV !== expV) begin
        fails++;
        $display("FAIL %s: {awV,awR,arV,arR} actual %b expected %b", tagV, gotV, expV);
      end
    end
  end

  task automatic cyc(string tag);
    bit wDn, rDn, wOn, rOn, cOn, wOk, rOk, cOk, cTwo, conf, gw, gr, hsW, hsR;
    int s;
    @(negedge clk);
    wDn = wForce || (wLat > 0 && mWr > 0 && wTmr >= wLat);
    rDn = rForce || (rLat > 0 && mRd > 0 && rTmr >= rLat);
    awValidIn = awV; awReadyIn = awR; arValidIn = arV; arReadyIn = arR;
    wrRespDone = wDn; rdRespDone = rDn;
    wOn = enable[0] && (wrLimInt != 0 || wrLimFrac != 0) && int'(wrLimInt) < WCEIL;
    rOn = enable[1] && (rdLimInt != 0 || rdLimFrac != 0) && int'(rdLimInt) < RCEIL;
    cOn = enable[2] && (cbLimInt != 0 || cbLimFrac != 0) && int'(cbLimInt) < WCEIL + RCEIL;
    wOk = mWr < WCEIL && (!wOn || admitF(mWr, int'(wrLimInt), int'(wrLimFrac), accW));
    rOk = mRd < RCEIL && (!rOn || admitF(mRd, int'(rdLimInt), int'(rdLimFrac), accR));
    s = mWr + mRd;
    cOk  = !cOn || admitF(s, int'(cbLimInt), int'(cbLimFrac), accC);
    cTwo = !cOn || admitF(s + 1, int'(cbLimInt), int'(cbLimFrac), accC);
    conf = awV && arV && wOk && rOk && cOk && !cTwo;
    gw = wOk && cOk && !(conf && mPref);
    gr = rOk && cOk && !(conf && !mPref);
    expQ.push_back({awV && gw, awR && gw, arV && gr, arR && gr});
    tagQ.push_back(tag);
    hsW = awV && gw && awR;
    hsR = arV && gr && arR;
    @(posedge clk);
    accW = stepAcc(enable[0] && wrLimFrac != 0, accW, mWr, int'(wrLimInt), int'(wrLimFrac));
    accR = stepAcc(enable[1] && rdLimFrac != 0, accR, mRd, int'(rdLimInt), int'(rdLimFrac));
    accC = stepAcc(enable[2] && cbLimFrac != 0, accC, s, int'(cbLimInt), int'(cbLimFrac));
    if (conf && (mPref ? hsR : hsW)) mPref = !mPref;
    wTmr = (wDn || mWr == 0) ? 0 : wTmr + 1;
    rTmr = (rDn || mRd == 0) ? 0 : rTmr + 1;
    mWr = mWr + int'(hsW) - int'(wDn && mWr > 0);
    mRd = mRd + int'(hsR) - int'(rDn && mRd > 0);
    #1;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic drain();
    awV = 0; arV = 0; wForce = 0; rForce = 0; wLat = 1; rLat = 1;
    for (int i = 0; i < 200 && (mWr > 0 || mRd > 0); i++) cyc("R1 drain");
    wLat = 0; rLat = 0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mWr = 0; mRd = 0; accW = 0; accR = 0; accC = 0; mPref = 0; wTmr = 0; rTmr = 0;
    wLat = 0; rLat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R10: reset state, idle outputs
    run(2, "R10 reset idle");

    // R9: transparent while disabled
    awV = 1; awR = 0; arV = 1; arR = 1;
    run(2, "R9 bypass");
    drain();

    // R2 ceiling, then R1 issue and completion together
    awV = 1; awR = 1;
    run(6, "R2 write ceiling");
    wForce = 1;
    run(3, "R1 issue with completion");
    wForce = 0;
    arV = 1; arR = 1; awV = 0;
    run(6, "R2 read ceiling");
    drain();

    // R3 whole-number limit on writes and reads
    enable = 3'b011; wrLimInt = 2; rdLimInt = 1;
    awV = 1; awR = 1; arV = 1; arR = 1;
    run(5, "R3 integer limit");
    drain();

    // R4 limits with no effect
    wrLimInt = 6; rdLimInt = 0; rdLimFrac = 0;
    awV = 1; awR = 1; arV = 1; arR = 1;
    run(6, "R4 over-ceiling and zero limit");
    drain();

    // R5 fractional limit of 0.5 with a slow responder
    wrLimInt = 0; wrLimFrac = 8'h80; enable = 3'b001;
    awV = 1; awR = 1; wLat = 10;
    run(200, "R5 fractional pacing");
    // R10 re-enable restarts the accumulator
    enable = 3'b000;
    run(1, "R10 disable");
    enable = 3'b001;
    run(40, "R10 re-enable");
    drain();

    // R6 combined cap of 6 over ceilings of 4 and 4
    enable = 3'b100; wrLimFrac = 0; cbLimInt = 6; cbLimFrac = 0;
    awV = 1; awR = 1;
    run(5, "R6 writes fill");
    awV = 0; arV = 1; arR = 1;
    run(4, "R6 reads capped at two");
    arV = 0; wForce = 1;
    run(2, "R6 release writes");
    wForce = 0; arV = 1;
    run(4, "R6 reads up to four");
    drain();

    // R6 combined fractional limit
    cbLimInt = 1; cbLimFrac = 8'h40;
    awV = 1; awR = 1; wLat = 5;
    run(60, "R6 combined fraction");
    drain();

    // R7 alternation with one combined slot
    cbLimInt = 1; cbLimFrac = 0;
    awV = 1; awR = 1; arV = 1; arR = 1; wLat = 2; rLat = 2;
    run(30, "R7 alternation");
    drain();

    // R8 ready low blocks acceptance
    enable = 3'b000;
    awV = 1; awR = 0; arV = 1; arR = 0;
    run(3, "R8 downstream not ready");
    awR = 1;
    run(1, "R8 accept");
    drain();

    finished = 1;
    @(negedge clk); #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule